// File: doc/BRIEF.md
# Serial Configuration Memory Bulk Dump Reader

This block is the readout path of a small serial configuration memory. It holds a 1024-bit array as a register file. The array is split into 64 words of 16 bits, and a word-wide preload port fills it. The serial side has three signals: an active-high chip select, an external serial clock and a data-out pin with an output enable. Together they model a tri-state pin.

A rising edge on the download-request input arms a streaming mode. The next time the device is selected, the whole array is shifted out one bit per serial clock. There is no command or address phase. Data starts at bit address 0, most significant bit of word 0 first. Dropping chip select ends the mode, and only a new request edge can start another dump. The serial clock, chip select and request are brought into the system clock through two-flop synchronisers. Edges are detected after the synchronisers.

The controller is a three-state machine:
- **IDLE**: not in dump mode. The IDLE→ARMED transition is taken on a request edge.
- **ARMED**: a request edge has been seen. The ARMED→STREAM transition is taken when chip select is high.
- **STREAM**: bits are driven out. The STREAM→IDLE transition is taken when chip select is low.

Top module: `cfg_dump_reader`

## Requirements
- R1: After reset the machine is in IDLE, `dout_oe` is 0 and `dout` is 0.
- R2: Only a 0→1 transition of `dl_req` moves IDLE to ARMED. Selecting the device with no prior edge, or with `dl_req` held high since an earlier dump, does not enable the output.
- R3: In ARMED, chip select high enters STREAM. `dout_oe` rises and `dout` presents bit address 0, which is bit 15 of word 0.
- R4: Bit address a maps to word a/16, bit position 15 − (a mod 16). Each rising serial-clock edge in STREAM advances the address by exactly one.
- R5: `dout` changes only after a falling serial-clock edge. It holds its value across a rising edge.
- R6: After bit address 1023, further clocking wraps to address 0 and then continues with 1, 2, and so on.
- R7: Chip select low in STREAM returns to IDLE and drops `dout_oe`. Reselecting without a fresh request edge streams nothing.
- R8: `dout_oe` is never high in the cycle after synchronised chip select is seen low.
- R9: Request edges that arrive during STREAM are ignored. The address sequence continues undisturbed.
- R10: A preload write with `pre_we` high stores `pre_data` into word `pre_word` on the next clock, and the next dump reads it out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_req | input | 1 | Dump request; its rising edge arms streaming |
| sel | input | 1 | Chip select, active high, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| pre_we | input | 1 | Preload write enable |
| pre_word | input | 6 | Preload word index |
| pre_data | input | 16 | Preload word data |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |

## Verification
The bench dumps all 1024 bits and clocks on into the wrap. An off-by-one wrap or a wrong bit order in a word would show the wrong bit at address 0, or one bit shifted by position. It samples `dout` after each rising edge as well as after each falling edge. This catches a design that updates on the wrong edge, because its data would run one bit ahead. It reselects with `dl_req` still high after an exit, and pulses the request mid-stream. A level-sensitive arm would restart or keep streaming, and a design that honoured the mid-stream edge would jump back to address 0.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_STREAM = 2'd2
    } dump_state_e;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? async_in : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cdr_bitstore.sv
module cdr_bitstore #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 64,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int WIDX_W = $clog2(WORDS),
    localparam int PTR_W  = WIDX_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic              rd_bit
);
    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WORD_W-1:0] rd_word;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[w] <= '0;
            end else if (wr_en && (wr_word == WIDX_W'(w))) begin
                mem_q[w] <= wr_data;
            end
        end
    end

    // MSB first inside a word: inverting the low index gives WORD_W-1-i
    assign rd_word = mem_q[rd_addr[PTR_W-1:BIT_W]];
    assign rd_bit  = rd_word[~rd_addr[BIT_W-1:0]];
endmodule

// File: rtl/cfg_dump_reader.sv
module cfg_dump_reader
    import cdr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dl_req,
    input  logic                     sel,
    input  logic                     sclk,
    input  logic                     pre_we,
    input  logic [$clog2(WORDS)-1:0] pre_word,
    input  logic [WORD_W-1:0]        pre_data,
    output logic                     dout,
    output logic                     dout_oe
);
    localparam int BITS  = WORD_W * WORDS;
    localparam int PTR_W = $clog2(BITS);
    localparam logic [PTR_W-1:0] LAST_ADDR = PTR_W'(BITS - 1);

    logic [2:0] sync_bus;
    logic       dl_s, sel_s, sclk_s;
    logic       dl_q, sclk_q;
    logic       dl_rise, sclk_rise, sclk_fall;

    dump_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             dout_q;
    logic             rd_bit;
    logic             load_bit, step_ptr;

    cdr_sync #(.W(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dl_req, sel, sclk}),
        .sync_out (sync_bus)
    );
    assign {dl_s, sel_s, sclk_s} = sync_bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            dl_q   <= dl_s;
            sclk_q <= sclk_s;
        end
    end

    assign dl_rise   = dl_s & ~dl_q;
    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;

    cdr_bitstore #(.WORD_W(WORD_W), .WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pre_we),
        .wr_word (pre_word),
        .wr_data (pre_data),
        .rd_addr (ptr_q),
        .rd_bit  (rd_bit)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (dl_rise) state_d = ST_ARMED;
            ST_ARMED:  if (sel_s)   state_d = ST_STREAM;
            ST_STREAM: if (!sel_s)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and datapath controls
    always_comb begin
        load_bit = 1'b0;
        step_ptr = 1'b0;
        dout_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARMED:  load_bit = sel_s;
            ST_STREAM: begin
                dout_oe  = 1'b1;
                load_bit = sel_s & sclk_fall;
                step_ptr = sel_s & sclk_rise;
            end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            dout_q <= 1'b0;
        end else begin
            if (state_q != ST_STREAM) begin
                ptr_q <= '0;
            end else if (step_ptr) begin
                ptr_q <= (ptr_q == LAST_ADDR) ? '0 : ptr_q + 1'b1;
            end
            if (load_bit) begin
                dout_q <= rd_bit;
            end
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/cfg_dump_reader_chk.sv
module cfg_dump_reader_chk
    import cdr_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int LAST  = 1023
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_s,
    input logic             dl_rise,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input dump_state_e      state,
    input logic [PTR_W-1:0] ptr,
    input logic             dout,
    input logic             dout_oe
);
    assert_arm_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !dl_rise) |=> (state == ST_IDLE));

    assert_stream_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_STREAM));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && sel_s && sclk_rise && ptr != PTR_W'(LAST))
        |=> (ptr == $past(ptr) + 1'b1));

    assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !sclk_fall) |=> $stable(dout));

    assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && sel_s && sclk_rise && ptr == PTR_W'(LAST))
        |=> (ptr == '0));

    assert_exit_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !sel_s) |=> (state == ST_IDLE));

    assert_oe_off_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> !dout_oe);

    assert_edge_ignored_streaming_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && sel_s && dl_rise && !sclk_rise) |=> $stable(ptr));
endmodule

bind cfg_dump_reader cfg_dump_reader_chk #(.PTR_W(PTR_W), .LAST(BITS - 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .dl_rise   (dl_rise),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .state     (state_q),
    .ptr       (ptr_q),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/cfg_dump_reader_bench.sv
module cfg_dump_reader_bench;
    localparam int WORD_W = 16;
    localparam int WORDS  = 64;
    localparam int BITS   = WORD_W * WORDS;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dl_req = 1'b0, sel = 1'b0, sclk = 1'b0, pre_we = 1'b0;
    logic [5:0] pre_word = '0;
    logic [WORD_W-1:0] pre_data = '0;
    logic dout, dout_oe;

    logic [WORD_W-1:0] model [WORDS];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_dump_reader #(.WORD_W(WORD_W), .WORDS(WORDS)) u_cfg_dump_reader (
        .clk(clk), .rst_n(rst_n), .dl_req(dl_req), .sel(sel), .sclk(sclk),
        .pre_we(pre_we), .pre_word(pre_word), .pre_data(pre_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_bit(input int a);
        int idx = a % BITS;
        return model[idx / WORD_W][WORD_W - 1 - (idx % WORD_W)];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic preload(input logic [WORD_W-1:0] seed);
        for (int w = 0; w < WORDS; w++) begin
            pre_we   = 1'b1;
            pre_word = 6'(w);
            pre_data = WORD_W'(w * 16'h9E37) ^ seed;
            model[w] = pre_data;
            wait_clk(1);
        end
        pre_we = 1'b0;
        wait_clk(1);
    endtask

    task automatic serial_bit(input int k, input string req);
        sclk = 1'b1;
        wait_clk(HALF);
        check("R5 hold across rise", dout, exp_bit(k - 1));
        sclk = 1'b0;
        wait_clk(HALF);
        check(req, dout, exp_bit(k));
    endtask

    task automatic t_reset();
        check("R1 oe", dout_oe, 1'b0);
        check("R1 dout", dout, 1'b0);
    endtask

    task automatic t_select_no_edge();
        sel = 1'b1;
        wait_clk(HALF);
        check("R2 no edge no stream", dout_oe, 1'b0);
        sel = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic t_full_dump();
        dl_req = 1'b1;
        wait_clk(6);
        check("R8 armed but unselected", dout_oe, 1'b0);
        sel = 1'b1;
        wait_clk(HALF);
        check("R3 oe", dout_oe, 1'b1);
        check("R3 first bit", dout, exp_bit(0));
        for (int k = 1; k < BITS; k++) serial_bit(k, "R4 order");
        serial_bit(BITS, "R6 wrap to 0");
        serial_bit(BITS + 1, "R6 after wrap");
        sel = 1'b0;
        wait_clk(6);
        check("R7 exit oe", dout_oe, 1'b0);
    endtask

    task automatic t_reselect_level_high();
        sel = 1'b1;
        wait_clk(HALF);
        check("R7 no restream without edge", dout_oe, 1'b0);
        check("R2 held level no arm", dout_oe, 1'b0);
        sel = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic t_rearm_and_midstream_edge();
        dl_req = 1'b0;
        wait_clk(6);
        preload(16'h3C5A);
        dl_req = 1'b1;
        wait_clk(6);
        sel = 1'b1;
        wait_clk(HALF);
        check("R10 new word 0 first bit", dout, exp_bit(0));
        for (int k = 1; k <= 5; k++) serial_bit(k, "R10 new data");
        dl_req = 1'b0;
        wait_clk(6);
        dl_req = 1'b1;
        wait_clk(6);
        check("R9 oe kept", dout_oe, 1'b1);
        for (int k = 6; k <= 20; k++) serial_bit(k, "R9 sequence continues");
        sel = 1'b0;
        wait_clk(6);
        check("R8 oe off", dout_oe, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        preload(16'hA5C3);
        t_select_no_edge();
        t_full_dump();
        t_reselect_level_high();
        t_rearm_and_midstream_edge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule